// File: doc/BRIEF.md
# Sixteen-bit compare timer with forced match

The block is a 16-bit up-counter with three output-compare channels, called A, B and C. Each channel drives one waveform pin and one sticky match flag. The counter advances on a one-cycle `tick` enable. In plain counting mode it wraps from 0xFFFF to zero. In clear-on-compare mode channel A's compare value sets the period. Each compare hit applies the channel's 2-bit output action to its pin.

Software reaches the block over an 8-bit register bus. Sixteen-bit values move through one shared 8-bit high-byte holding register, so both bytes always transfer together. A force register lets software apply a channel's output action at once. A forced action leaves the flags and the counter untouched. Any bus write to the counter suppresses every compare hit on the following tick.

Top module: `cmp_timer16`

## Requirements
- R1: After a synchronous active-low reset the following read as zero: the counter, all compare values, the mode, the action field, the pins and the flags.
- R2: Each `tick` advances the counter by one. In mode 00 (plain counting) it wraps from 0xFFFF to 0x0000. Without a tick it holds.
- R3: Mode register (address 8, bits [1:0]) code 01 selects clear-on-compare. A tick that finds the counter equal to channel A's compare value, with no suppression pending, loads zero. The period is therefore compare-A plus one ticks.
- R4: A tick that finds the counter equal to channel i's compare value, with no suppression pending, sets flag i. The flag stays set until a one is written to bit i of the flag register (address 11). Writing a zero bit has no effect.
- R5: On a compare hit a channel updates its pin according to its 2-bit action field, which sits at address 9, bits [2i+1:2i]. The codes are 00 hold, 01 toggle, 10 drive low and 11 drive high.
- R6: Writing a one to bit i of the force register (address 10) applies channel i's current action to its pin at that clock edge. A forced action sets no flag and, in mode 01, does not clear the counter.
- R7: Mode codes 10 and 11 are pulse-width-class codes. The counter then counts as in mode 00, flags still set, and neither forces nor hits move the pins. The force register always reads as zero.
- R8: A bus write to the counter blocks compare hits on all channels for the next tick. That tick still advances the counter. In mode 01 it also does not clear the counter.
- R9: The 16-bit registers are mapped as follows: counter at 0/1, compare A at 2/3, compare B at 4/5, compare C at 6/7. The even address holds the low byte. A high-byte write loads only the shared holding register. A low-byte write commits {holding, data} to that register in one cycle.
- R10: A low-byte read returns the live low byte and copies that register's high byte into the holding register. A high-byte read returns the holding register.
- R11: When a force and a real hit reach the same channel in one cycle, the action is applied once and the flag is set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (updates holding register on low-byte reads) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| wave_out | output | 3 | Waveform pins, bit i for channel i |
| cmp_flag | output | 3 | Sticky compare-match flags, bit i for channel i |

## Verification
A forced action and a genuine compare hit can land on the same channel in the same cycle. The bench provokes this by issuing the force-register write with `tick` raised on the very cycle the counter equals all three compare values. It judges the result by the toggled pins: each must have changed exactly once, because a double application would cancel. All three flags must also be set. A second case pairs a counter write with the suppressed tick that follows. The bench checks that the flags stay clear while the count still moves.

// File: rtl/cmp_timer16_pkg.sv
// Shared types and helpers for the 16-bit compare timer.
// Assumes two-bit mode and action codes as listed in the brief.
package cmp_timer16_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_CTC   = 2'b01,
        MODE_PWM_X = 2'b10,
        MODE_PWM_Y = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } out_act_e;

    // Next pin level for a given action and current level.
    function automatic logic next_pin(input logic [1:0] act, input logic cur);
        case (out_act_e'(act))
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

    // Pulse-width-class codes have the upper bit set.
    function automatic logic mode_is_pwm(input wave_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/cmp_timer16_regbus.sv
// Register decode for the compare timer: shared high-byte holding register,
// control fields, force strobes and flag-clear strobes, and the read mux.
// Assumes bus_we and bus_re are never raised together.
module cmp_timer16_regbus
    import cmp_timer16_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int N_CH   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic                    bus_re,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BUS_W-1:0]        bus_wdata,
    input  logic [2*BUS_W-1:0]      cnt_val,
    input  logic [N_CH*2*BUS_W-1:0] cmp_flat,
    input  logic [N_CH-1:0]         flags,
    output logic [BUS_W-1:0]        bus_rdata,
    output logic [N_CH:0]           wide_wr,
    output logic [2*BUS_W-1:0]      wide_wdata,
    output wave_mode_e              mode,
    output logic [2*N_CH-1:0]       act_bits,
    output logic [N_CH-1:0]         force_stb,
    output logic [N_CH-1:0]         flag_clr
);
    localparam int CNT_W  = 2 * BUS_W;
    localparam int N_WIDE = N_CH + 1;
    localparam int IDX_W  = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(2 * N_WIDE);
    localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(2 * N_WIDE + 1);
    localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(2 * N_WIDE + 2);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(2 * N_WIDE + 3);

    logic [BUS_W-1:0] hold_q;
    logic [CNT_W-1:0] wide_val [N_WIDE];
    logic [CNT_W-1:0] sel_val;
    logic             is_wide;
    logic             is_lo;
    logic [IDX_W-1:0] wide_idx;

    assign is_wide  = (bus_addr < A_MODE);
    assign is_lo    = ~bus_addr[0];
    assign wide_idx = bus_addr[ADDR_W-1:1];

    // Gather the counter and compare values into one indexed view.
    assign wide_val[0] = cnt_val;
    for (genvar g = 0; g < N_CH; g++) begin : g_val
        assign wide_val[g+1] = cmp_flat[g*CNT_W +: CNT_W];
    end

    // Select the 16-bit register addressed by the current bus cycle.
    always_comb begin
        sel_val = '0;
        for (int k = 0; k < N_WIDE; k++) begin
            if (wide_idx == IDX_W'(k)) sel_val = wide_val[k];
        end
    end

    // Per-register commit strobes for low-byte writes.
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wr
        assign wide_wr[g] = bus_we && is_wide && is_lo && (wide_idx == IDX_W'(g));
    end
    assign wide_wdata = {hold_q, bus_wdata};

    // Shared holding register: loaded by high writes and by low reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                               hold_q <= '0;
        else if (bus_we && is_wide && !is_lo)     hold_q <= bus_wdata;
        else if (bus_re && is_wide && is_lo)      hold_q <= sel_val[CNT_W-1:BUS_W];
    end

    // Mode and action control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_PLAIN;
            act_bits <= '0;
        end else if (bus_we && bus_addr == A_MODE) begin
            mode     <= wave_mode_e'(bus_wdata[1:0]);
        end else if (bus_we && bus_addr == A_ACT) begin
            act_bits <= bus_wdata[2*N_CH-1:0];
        end
    end

    // One-cycle strobes decoded straight from the write.
    assign force_stb = (bus_we && bus_addr == A_FORCE) ? bus_wdata[N_CH-1:0] : '0;
    assign flag_clr  = (bus_we && bus_addr == A_FLAG)  ? bus_wdata[N_CH-1:0] : '0;

    // Read mux; the force register has no storage and reads zero.
    always_comb begin
        if (is_wide && is_lo)        bus_rdata = sel_val[BUS_W-1:0];
        else if (is_wide)            bus_rdata = hold_q;
        else if (bus_addr == A_MODE) bus_rdata = BUS_W'(mode);
        else if (bus_addr == A_ACT)  bus_rdata = BUS_W'(act_bits);
        else if (bus_addr == A_FLAG) bus_rdata = BUS_W'(flags);
        else                         bus_rdata = '0;
    end

    // R7
    force_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_FORCE) |-> (bus_rdata == '0));

    // R9
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && is_wide && !is_lo) |=> (hold_q == $past(bus_wdata)));

endmodule

// File: rtl/cmp_timer16_counter.sv
// Counter core: counts on tick, clears on a channel-A hit in CTC mode and
// holds a one-tick suppression flag after every bus write to the count.
// Assumes ctc_hit already excludes suppressed ticks.
module cmp_timer16_counter
    import cmp_timer16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             ctc_hit,
    input  wave_mode_e       mode,
    output logic [CNT_W-1:0] cnt,
    output logic             blk
);
    // Count register with write priority over tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            blk <= 1'b0;
        end else if (wr_en) begin
            cnt <= wr_val;
            blk <= 1'b1;
        end else if (tick) begin
            blk <= 1'b0;
            cnt <= (ctc_hit && mode == MODE_CTC) ? '0 : cnt + 1'b1;
        end
    end

    // R2
    wrap_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && mode == MODE_PLAIN && cnt == '1) |=> (cnt == '0));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt));

    // R3
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && ctc_hit && mode == MODE_CTC) |=> (cnt == '0));

endmodule

// File: rtl/cmp_timer16_chan.sv
// One compare channel: holds its compare value, detects hits on tick,
// drives its waveform pin and keeps a sticky match flag.
// Assumes force_stb and flag_clr are single-cycle strobes.
module cmp_timer16_chan
    import cmp_timer16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             blk,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       act,
    input  logic             pwm,
    input  logic             force_stb,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cmp_val,
    output logic             hit,
    output logic             pin,
    output logic             flag
);
    // Compare value storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (cmp_wr) cmp_val <= cmp_wdata;
    end

    // A real hit needs a tick, no pending suppression and equality.
    assign hit = tick && !blk && (cnt == cmp_val);

    // Pin update, applied once for a hit, a force, or both together.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pin <= 1'b0;
        else if (!pwm && (hit || force_stb)) pin <= next_pin(act, pin);
    end

    // Sticky flag: set by real hits only, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // R6
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !hit) |=> $stable(flag));

    // R7
    pwm_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |=> $stable(pin));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R11
    single_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && force_stb && !pwm && act == 2'b01) |=> (pin != $past(pin)));

endmodule

// File: rtl/cmp_timer16.sv
// Top of the 16-bit compare timer: register bus, counter core and one
// compare channel per output pin. Channel 0 (A) sets the CTC period.
// Assumes the bus never reads and writes in the same cycle.
module cmp_timer16
    import cmp_timer16_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int N_CH   = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   wave_out,
    output logic [N_CH-1:0]   cmp_flag
);
    localparam int CNT_W = 2 * BUS_W;

    logic [N_CH:0]         wide_wr;
    logic [CNT_W-1:0]      wide_wdata;
    wave_mode_e            mode;
    logic [2*N_CH-1:0]     act_bits;
    logic [N_CH-1:0]       force_stb;
    logic [N_CH-1:0]       flag_clr;
    logic [N_CH*CNT_W-1:0] cmp_flat;
    logic [N_CH-1:0]       hit_vec;
    logic [CNT_W-1:0]      cnt;
    logic                  blk;
    logic                  pwm;

    assign pwm = mode_is_pwm(mode);

    cmp_timer16_regbus #(.BUS_W(BUS_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_val    (cnt),
        .cmp_flat   (cmp_flat),
        .flags      (cmp_flag),
        .bus_rdata  (bus_rdata),
        .wide_wr    (wide_wr),
        .wide_wdata (wide_wdata),
        .mode       (mode),
        .act_bits   (act_bits),
        .force_stb  (force_stb),
        .flag_clr   (flag_clr)
    );

    cmp_timer16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wide_wr[0]),
        .wr_val  (wide_wdata),
        .ctc_hit (hit_vec[0]),
        .mode    (mode),
        .cnt     (cnt),
        .blk     (blk)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        cmp_timer16_chan #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .blk       (blk),
            .cnt       (cnt),
            .cmp_wr    (wide_wr[g+1]),
            .cmp_wdata (wide_wdata),
            .act       (act_bits[2*g +: 2]),
            .pwm       (pwm),
            .force_stb (force_stb[g]),
            .flag_clr  (flag_clr[g]),
            .cmp_val   (cmp_flat[g*CNT_W +: CNT_W]),
            .hit       (hit_vec[g]),
            .pin       (wave_out[g]),
            .flag      (cmp_flag[g])
        );
    end

    // R8
    write_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide_wr[0] |=> (tick |-> (hit_vec == '0)));

    // R6
    force_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb[0] && mode == MODE_CTC && !tick && !wide_wr[0]) |=> (cnt == $past(cnt)));

endmodule

// File: tb/sim_cmp_timer16.sv
module sim_cmp_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] wave_out;
    logic [2:0] cmp_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit reported = 0;
    logic [2:0] exp_pin = '0;

    always #2.5 clk = ~clk;

    cmp_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_out(wave_out), .cmp_flag(cmp_flag)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic mdl(input int c, input logic p);
        case (c)
            1: return ~p;
            2: return 1'b0;
            3: return 1'b1;
            default: return p;
        endcase
    endfunction

    task automatic bus_op(input logic we, input logic re, input logic [3:0] a,
                          input logic [7:0] d, input logic tk, output logic [7:0] q);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; tick = tk;
        #1 q = bus_rdata;
        @(posedge clk);
        #1;
        bus_we = 0; bus_re = 0; tick = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] q;
        bus_op(1, 0, a, d, 0, q);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] q);
        bus_op(0, 1, a, 8'h00, 0, q);
    endtask

    task automatic tk();
        logic [7:0] q;
        bus_op(0, 0, 4'd15, 8'h00, 1, q);
    endtask

    task automatic wr16(input logic [3:0] base, input logic [15:0] v);
        wr(base + 4'd1, v[15:8]);
        wr(base, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] base, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(base, lo);
        rd(base + 4'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int e;
        logic [15:0] pats [4];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA55A; pats[3] = 16'h3C0F;

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            rd16(4'(2 * r), v);
            chk("R1 wide reg after reset", v, 16'h0000);
        end
        rd(8, b);  chk("R1 mode after reset", b, 8'h00);
        rd(9, b);  chk("R1 action after reset", b, 8'h00);
        rd(11, b); chk("R1 flags after reset", b, 8'h00);
        chk("R1 pins after reset", wave_out, 3'b000);

        // R9 full 16-bit write/read sweep
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 4; p++) begin
                wr16(4'(2 * r), pats[p] ^ 16'(r));
                rd16(4'(2 * r), v);
                chk("R9 16-bit round trip", v, pats[p] ^ 16'(r));
            end
        end
        // R9 high write alone does not change the target
        wr(5, 8'h77);
        rd16(4, v);
        chk("R9 high-only write leaves compare B", v, 16'h3C0F ^ 16'd2);
        // R9 holding register is shared across registers
        wr(5, 8'h9C);
        wr(2, 8'h11);
        rd16(2, v);
        chk("R9 shared holding commit into compare A", v, 16'h9C11);
        for (int r = 1; r < 4; r++) wr16(4'(2 * r), 16'h8000);

        // R10 low read snapshots the high byte
        wr16(0, 16'h12FE);
        tk();
        rd(0, b);
        chk("R10 live low byte", b, 8'hFF);
        tk();
        rd(1, b);
        chk("R10 high byte from snapshot", b, 8'h12);
        rd16(0, v);
        chk("R10 fresh read after carry", v, 16'h1300);

        // R2 increments across a byte carry and wraps at the top
        wr16(0, 16'h00FA);
        tk();
        for (int i = 0; i < 8; i++) begin
            tk();
            rd16(0, v);
            chk("R2 increment", v, 16'h00FC + 16'(i));
        end
        wr16(0, 16'hFFFE);
        tk();
        rd16(0, v); chk("R2 reach top", v, 16'hFFFF);
        tk();
        rd16(0, v); chk("R2 wrap to zero", v, 16'h0000);
        tk();
        rd16(0, v); chk("R2 count after wrap", v, 16'h0001);
        wr(11, 8'h07);

        // R3 CTC period sweep over small TOP values
        wr(8, 8'h01);
        for (int top = 1; top <= 4; top++) begin
            wr16(2, 16'(top));
            wr16(0, 16'h0000);
            wr(11, 8'h07);
            tk();
            e = 1;
            for (int i = 0; i < 2 * (top + 1) + 1; i++) begin
                tk();
                e = (e == top) ? 0 : e + 1;
                rd16(0, v);
                chk("R3 CTC count", v, 16'(e));
            end
            chk("R3 CTC flag A set", cmp_flag, 3'b001);
        end

        // R8 counter write blocks the next tick's hits
        wr(8, 8'h00);
        for (int r = 1; r < 4; r++) wr16(4'(2 * r), 16'h0005);
        wr(11, 8'h07);
        wr16(0, 16'h0005);
        tk();
        chk("R8 no flags on blocked tick", cmp_flag, 3'b000);
        rd16(0, v); chk("R8 blocked tick still counts", v, 16'h0006);
        wr16(0, 16'h0004);
        tk();
        tk();
        chk("R4 all flags set by hit", cmp_flag, 3'b111);
        wr(11, 8'h02);
        chk("R4 clear only flag B", cmp_flag, 3'b101);
        wr(11, 8'h00);
        chk("R4 zero write keeps flags", cmp_flag, 3'b101);
        wr(8, 8'h01);
        wr16(0, 16'h0005);
        tk();
        rd16(0, v); chk("R8 CTC not cleared on blocked tick", v, 16'h0006);
        wr(8, 8'h00);

        // R5 hit actions, each code applied to all channels
        for (int rep = 0; rep < 2; rep++) begin
            for (int c = 0; c < 4; c++) begin
                wr(9, 8'((c << 4) | (c << 2) | c));
                wr(11, 8'h07);
                wr16(0, 16'h0004);
                tk();
                tk();
                for (int i = 0; i < 3; i++) exp_pin[i] = mdl(c, exp_pin[i]);
                chk("R5 pins after hit", wave_out, exp_pin);
                chk("R4 flags after hit", cmp_flag, 3'b111);
            end
        end
        // R5 mixed actions: A toggle, B low, C high
        wr(9, 8'h39);
        wr16(0, 16'h0004);
        tk(); tk();
        exp_pin[0] = ~exp_pin[0]; exp_pin[1] = 1'b0; exp_pin[2] = 1'b1;
        chk("R5 mixed actions", wave_out, exp_pin);

        // R6 force sweep per channel and code
        wr(11, 8'h07);
        for (int ch = 0; ch < 3; ch++) begin
            for (int rep = 0; rep < 2; rep++) begin
                for (int c = 0; c < 4; c++) begin
                    wr(9, 8'(c << (2 * ch)));
                    wr(10, 8'(1 << ch));
                    exp_pin[ch] = mdl(c, exp_pin[ch]);
                    chk("R6 forced pin", wave_out, exp_pin);
                    chk("R6 force sets no flag", cmp_flag, 3'b000);
                end
            end
        end
        rd(10, b);
        chk("R7 force register reads zero", b, 8'h00);
        // R6 force in CTC with counter at TOP does not clear the count
        wr(8, 8'h01);
        wr(9, 8'h01);
        wr16(2, 16'h0005);
        wr16(0, 16'h0005);
        wr(10, 8'h01);
        exp_pin[0] = ~exp_pin[0];
        chk("R6 CTC force pin", wave_out, exp_pin);
        rd16(0, v);
        chk("R6 CTC force keeps count", v, 16'h0005);
        chk("R6 CTC force no flag", cmp_flag, 3'b000);

        // R7 pulse-width-class codes block pin changes
        for (int m = 2; m < 4; m++) begin
            wr(8, 8'(m));
            wr(9, 8'h15);
            wr(10, 8'h07);
            chk("R7 force ignored", wave_out, exp_pin);
            wr(11, 8'h07);
            wr16(0, 16'h0004);
            tk(); tk();
            chk("R7 hit leaves pins", wave_out, exp_pin);
            chk("R7 flags still set", cmp_flag, 3'b111);
        end

        // R11 force and hit on the same cycle
        wr(8, 8'h00);
        wr(9, 8'h15);
        wr16(0, 16'h0004);
        tk();
        wr(11, 8'h07);
        bus_op(1, 0, 4'd10, 8'h01, 1, b);
        exp_pin = ~exp_pin;
        chk("R11 single application", wave_out, exp_pin);
        chk("R11 flags set", cmp_flag, 3'b111);

        report();
    end
endmodule